// File: doc/BRIEF.md
# Iterative Sponge Permutation Round Engine

This block applies a 320-bit substitution-permutation transformation to a state, one round per clock, for a run of 1 to 12 rounds. The state is five 64-bit words, x0 to x4. Each round XORs an 8-bit constant into the low byte of x2. It then passes every bit slice through a 5-bit nonlinear S-box. Last, it mixes each word with two right rotations of itself. A surrounding mode controller loads a state, picks the run length (12 for the setup and finish phases, 6 or 8 between data blocks), waits for the done pulse and reads the result.

The control is a three-state machine. IDLE waits for a load. RUN applies one round per cycle. DONE lasts one cycle and raises the done pulse. The transitions are:
- IDLE -> RUN when the block is loaded.
- RUN -> RUN while rounds remain.
- RUN -> DONE after the last round.
- DONE -> RUN when a load arrives in the DONE cycle.
- DONE -> IDLE otherwise.

A load that arrives during RUN is dropped.

Top module: `spr_perm_core`

## Requirements
- R1: After reset, busy_o and done_o are 0 and state_o is all zeros.
- R2: A load_i sampled high while busy_o is low captures state_i, with x0 = state_i[319:256], x1 = [255:192], x2 = [191:128], x3 = [127:64] and x4 = [63:0]. On the next cycle busy_o is 1 and state_o equals the loaded value.
- R3: The run length N is rounds_i when rounds_i is 1 to 12. The values 0 and 13 to 15 select 12. busy_o stays high for exactly N cycles.
- R4: Rounds are numbered 12-N up to 11. Round r XORs the byte {4'(15-r), 4'(r)} into bits [7:0] of x2, giving 0xf0, 0xe1 and so on down to 0x4b.
- R5: The S-box layer maps each slice (a0..a4) = bit i of x0..x4, with a0 as the most significant bit, to the following outputs:
  - y0 = a4a1^a3^a2a1^a2^a1a0^a1^a0
  - y1 = a4^a3a2^a3a1^a3^a2a1^a2^a1^a0
  - y2 = a4a3^a4^a2^a1^1
  - y3 = a4a0^a4^a3a0^a3^a2^a1^a0
  - y4 = a4a1^a4^a3^a1a0^a1
- R6: The linear layer replaces each word with itself XOR two right rotations of itself. The rotation pairs are x0: 19 and 28, x1: 61 and 39, x2: 1 and 6, x3: 10 and 17, x4: 7 and 41.
- R7: done_o is high for exactly one cycle, the cycle after the last round, and state_o then holds the result of the N rounds.
- R8: After a run, state_o keeps its value until the next accepted load, whatever state_i does.
- R9: A load_i sampled while busy_o is high is ignored. The result, the run length and the round count of the current run are unchanged.
- R10: A load_i sampled during the done cycle is accepted, and a new run starts without an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load/start request |
| rounds_i | input | 4 | Requested number of rounds |
| state_i | input | 320 | State to transform, x0 in the top word |
| busy_o | output | 1 | High while rounds are being applied |
| done_o | output | 1 | One-cycle pulse once the run has finished |
| state_o | output | 320 | Working or final state |

## Verification
Two events can fall in the same cycle: the done pulse that ends one run, and the load that begins the next. The bench provokes this by holding load_i high with fresh data in the exact cycle where done_o is seen. It then judges the new run by its busy length and its result, computed from the slice equations and rotations. It also drives load_i in the middle of a run and checks that neither the run's result nor its cycle count moves.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int WORD_W  = 64;
    localparam int NWORDS  = 5;
    localparam int STATE_W = WORD_W * NWORDS;
    localparam int MAX_RND = 12;
    localparam int CNT_W   = 4;
    localparam int RC_W    = 2 * CNT_W;

    localparam int ROT_A [NWORDS] = '{19, 61, 1, 10, 7};
    localparam int ROT_B [NWORDS] = '{28, 39, 6, 17, 41};

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } fsm_t;

    function automatic word_t rotr(input word_t v, input int sh);
        return (v >> sh) | (v << (WORD_W - sh));
    endfunction
endpackage

// File: rtl/spr_rc_gen.sv
module spr_rc_gen
    import spr_pkg::*;
(
    input  logic [CNT_W-1:0] idx_i,
    output logic [RC_W-1:0]  rc_o
);
    localparam int HALF = RC_W / 2;

    logic [HALF-1:0] lo_nib;
    logic [HALF-1:0] hi_nib;

    // upper nibble counts down while the lower counts up
    always_comb begin
        lo_nib = HALF'(idx_i);
        hi_nib = ~lo_nib;
        rc_o   = {hi_nib, lo_nib};
    end
endmodule

// File: rtl/spr_sbox_layer.sv
module spr_sbox_layer
    import spr_pkg::*;
(
    input  word_t x_i [NWORDS],
    output word_t y_o [NWORDS]
);
    word_t pre  [NWORDS];
    word_t tmsk [NWORDS];
    word_t mid  [NWORDS];

    // input whitening between neighbouring words
    always_comb begin
        pre    = x_i;
        pre[0] = x_i[0] ^ x_i[4];
        pre[4] = x_i[4] ^ x_i[3];
        pre[2] = x_i[2] ^ x_i[1];
    end

    // chi core, one lane per word
    for (genvar i = 0; i < NWORDS; i++) begin : g_chi
        assign tmsk[i] = ~pre[i] & pre[(i + 1) % NWORDS];
    end
    for (genvar i = 0; i < NWORDS; i++) begin : g_mix
        assign mid[i] = pre[i] ^ tmsk[(i + 1) % NWORDS];
    end

    // output whitening and inversion of lane 2
    always_comb begin
        y_o    = mid;
        y_o[1] = mid[1] ^ mid[0];
        y_o[0] = mid[0] ^ mid[4];
        y_o[3] = mid[3] ^ mid[2];
        y_o[2] = ~mid[2];
    end
endmodule

// File: rtl/spr_lin_layer.sv
module spr_lin_layer
    import spr_pkg::*;
(
    input  word_t x_i [NWORDS],
    output word_t y_o [NWORDS]
);
    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        assign y_o[k] = x_i[k] ^ rotr(x_i[k], ROT_A[k]) ^ rotr(x_i[k], ROT_B[k]);
    end
endmodule

// File: rtl/spr_round.sv
module spr_round
    import spr_pkg::*;
(
    input  logic [STATE_W-1:0] s_i,
    input  logic [CNT_W-1:0]   idx_i,
    output logic [STATE_W-1:0] s_o
);
    logic [RC_W-1:0] rc;
    word_t w_in  [NWORDS];
    word_t w_add [NWORDS];
    word_t w_sub [NWORDS];
    word_t w_lin [NWORDS];

    spr_rc_gen u_rc (
        .idx_i (idx_i),
        .rc_o  (rc)
    );

    // word k sits at the top of the flat vector for k = 0
    for (genvar k = 0; k < NWORDS; k++) begin : g_unpack
        assign w_in[k] = s_i[STATE_W-1-k*WORD_W -: WORD_W];
        assign s_o[STATE_W-1-k*WORD_W -: WORD_W] = w_lin[k];
    end

    always_comb begin
        w_add    = w_in;
        w_add[2] = w_in[2] ^ WORD_W'(rc);
    end

    spr_sbox_layer u_sbox (
        .x_i (w_add),
        .y_o (w_sub)
    );

    spr_lin_layer u_lin (
        .x_i (w_sub),
        .y_o (w_lin)
    );
endmodule

// File: rtl/spr_perm_core.sv
module spr_perm_core
    import spr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [CNT_W-1:0]     rounds_i,
    input  logic [STATE_W-1:0]   state_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [STATE_W-1:0]   state_o
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_RND - 1);
    localparam logic [CNT_W-1:0] RND_MAX  = CNT_W'(MAX_RND);

    fsm_t               st_q, st_d;
    logic [CNT_W-1:0]   idx_q, idx_d;
    logic [STATE_W-1:0] s_q, s_d;
    logic [STATE_W-1:0] s_rnd;
    logic [CNT_W-1:0]   start_idx;

    spr_round u_round (
        .s_i   (s_q),
        .idx_i (idx_q),
        .s_o   (s_rnd)
    );

    // out-of-range counts fall back to a full run
    always_comb begin
        if (rounds_i == '0 || rounds_i > RND_MAX) begin
            start_idx = '0;
        end else begin
            start_idx = RND_MAX - rounds_i;
        end
    end

    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        s_d   = s_q;
        unique case (st_q)
            ST_IDLE, ST_DONE: begin
                if (load_i) begin
                    st_d  = ST_RUN;
                    idx_d = start_idx;
                    s_d   = state_i;
                end else begin
                    st_d  = ST_IDLE;
                end
            end
            ST_RUN: begin
                s_d = s_rnd;
                if (idx_q == LAST_IDX) begin
                    st_d = ST_DONE;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
            s_q   <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
            s_q   <= s_d;
        end
    end

    always_comb begin
        busy_o  = (st_q == ST_RUN);
        done_o  = (st_q == ST_DONE);
        state_o = s_q;
    end
endmodule

// File: rtl/spr_perm_core_chk.sv
module spr_perm_core_chk
    import spr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               load_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [STATE_W-1:0] state_o
);
    // R1: busy and done never overlap
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R2: an accepted load starts a run
    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !busy_o) |=> busy_o);

    // R3: a run always ends in the done cycle
    a_r3_run_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R7: done is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: result held while idle without a load
    a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !load_i) |=> $stable(state_o));

    // R9: a load during a run does not restart it
    a_r9_busy_load_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && load_i) |=> (busy_o || done_o));
endmodule

bind spr_perm_core spr_perm_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .state_o (state_o)
);

// File: tb/spr_perm_core_tb.sv
module spr_perm_core_tb;
    localparam int SW = 320;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [3:0]    rounds_i = 4'd0;
    logic [SW-1:0] state_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [SW-1:0] state_o;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    spr_perm_core u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .rounds_i (rounds_i),
        .state_i  (state_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .state_o  (state_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [SW-1:0] act, input logic [SW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model written from the slice equations
    function automatic logic [SW-1:0] ref_perm(input logic [SW-1:0] s, input int n);
        logic [63:0] x [5];
        logic [63:0] y [5];
        int ra [5] = '{19, 61, 1, 10, 7};
        int rb [5] = '{28, 39, 6, 17, 41};
        logic [SW-1:0] r;
        for (int k = 0; k < 5; k++) x[k] = s[SW-1-64*k -: 64];
        for (int rn = 12 - n; rn < 12; rn++) begin
            x[2][7:0] = x[2][7:0] ^ {4'(15 - rn), 4'(rn)};
            for (int b = 0; b < 64; b++) begin
                logic a0, a1, a2, a3, a4;
                a0 = x[0][b]; a1 = x[1][b]; a2 = x[2][b]; a3 = x[3][b]; a4 = x[4][b];
                y[0][b] = (a4&a1)^a3^(a2&a1)^a2^(a1&a0)^a1^a0;
                y[1][b] = a4^(a3&a2)^(a3&a1)^a3^(a2&a1)^a2^a1^a0;
                y[2][b] = (a4&a3)^a4^a2^a1^1'b1;
                y[3][b] = (a4&a0)^a4^(a3&a0)^a3^a2^a1^a0;
                y[4][b] = (a4&a1)^a4^a3^(a1&a0)^a1;
            end
            for (int k = 0; k < 5; k++) begin
                for (int b = 0; b < 64; b++) begin
                    x[k][b] = y[k][b] ^ y[k][(b + ra[k]) % 64] ^ y[k][(b + rb[k]) % 64];
                end
            end
        end
        for (int k = 0; k < 5; k++) r[SW-1-64*k -: 64] = x[k];
        return r;
    endfunction

    function automatic logic [SW-1:0] pattern(input int seed);
        logic [31:0] v;
        logic [SW-1:0] r;
        v = 32'(seed) * 32'd2654435761 + 32'd1;
        for (int i = 0; i < 10; i++) begin
            v = v * 32'd1103515245 + 32'd12345;
            r[32*i +: 32] = v ^ {v[15:0], v[31:16]};
        end
        return r;
    endfunction

    // every slice i carries the 5-bit value i mod 32 (x0 is its MSB)
    function automatic logic [SW-1:0] slice_sweep();
        logic [SW-1:0] r;
        for (int k = 0; k < 5; k++)
            for (int b = 0; b < 64; b++)
                r[SW-1-64*k-63+b] = 1'(((b % 32) >> (4 - k)) & 1);
        return r;
    endfunction

    task automatic do_run(input logic [SW-1:0] d, input logic [3:0] n,
                          input bit pre, input bit poke, input bit chain,
                          input logic [SW-1:0] nd, input logic [3:0] nn);
        int eff;
        int cyc;
        logic [SW-1:0] exp;
        eff = (n == 4'd0 || n > 4'd12) ? 12 : int'(n);
        exp = ref_perm(d, eff);
        if (!pre) begin
            @(negedge clk);
            state_i = d; rounds_i = n; load_i = 1'b1;
        end
        @(negedge clk);
        load_i = 1'b0;
        check(busy_o == 1'b1, "R2 busy after load", SW'(busy_o), SW'(1));
        check(state_o == d, "R2 loaded state", state_o, d);
        if (pre) check(done_o == 1'b0, "R10 chained start", SW'(done_o), SW'(0));
        cyc = 0;
        while (busy_o && cyc < 40) begin
            if (poke && cyc == 1) begin
                load_i = 1'b1; state_i = ~d; rounds_i = 4'd1;
            end else begin
                load_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        load_i = 1'b0;
        check(cyc == eff, poke ? "R9 run length kept" : "R3 busy length",
              SW'(cyc), SW'(eff));
        check(done_o == 1'b1, "R7 done pulse", SW'(done_o), SW'(1));
        check(state_o == exp, poke ? "R9 result kept" : "R4 R5 R6 result",
              state_o, exp);
        if (chain) begin
            state_i = nd; rounds_i = nn; load_i = 1'b1;
        end else begin
            @(negedge clk);
            check(done_o == 1'b0, "R7 done one cycle", SW'(done_o), SW'(0));
            check(state_o == exp, "R8 hold", state_o, exp);
            state_i = ~exp;
            @(negedge clk);
            check(state_o == exp, "R8 hold vs input", state_o, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2;
        check(busy_o == 1'b0, "R1 busy reset", SW'(busy_o), SW'(0));
        check(done_o == 1'b0, "R1 done reset", SW'(done_o), SW'(0));
        check(state_o == '0, "R1 state reset", state_o, '0);
        #20;
        @(negedge clk);
        rst_n = 1'b1;

        // R5: all 32 slice inputs in a single round
        do_run(slice_sweep(), 4'd1, 0, 0, 0, '0, 4'd0);
        do_run(slice_sweep(), 4'd12, 0, 0, 0, '0, 4'd0);
        do_run('0, 4'd6, 0, 0, 0, '0, 4'd0);
        do_run('1, 4'd8, 0, 0, 0, '0, 4'd0);

        // R3 R4: every count value, including the clamped ones
        for (int c = 0; c < 16; c++) begin
            do_run(pattern(c), 4'(c), 0, 0, 0, '0, 4'd0);
        end

        // R9: load pulse during a run
        do_run(pattern(100), 4'd6, 0, 1, 0, '0, 4'd0);
        do_run(pattern(101), 4'd12, 0, 1, 0, '0, 4'd0);

        // R10: next load in the done cycle
        do_run(pattern(200), 4'd8, 0, 0, 1, pattern(201), 4'd6);
        do_run(pattern(201), 4'd6, 1, 0, 1, pattern(202), 4'd12);
        do_run(pattern(202), 4'd12, 1, 0, 0, '0, 4'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule